// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous host request port to an external asynchronous static memory with 26 address lines and a 16-bit bidirectional data bus. The host presents one access at a time with a valid/ready handshake. The controller then runs that access on the memory pins in two timed phases. The first is an address-setup phase. The second is a data phase, in which output enable is asserted for a read and write enable for a write. When the data phase ends, the controller returns a one-cycle response pulse to the host, carrying the read data for a read.

The request channel follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` drops as soon as a request is taken. It stays low for the whole memory access and for the turnaround gap that follows. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must capture.

All durations come from a 32-bit timing word. Bits 3:0 give the setup length, bits 15:8 give the data length and bits 19:16 give the turnaround length. All other bits of the word are ignored. The timing word must be held stable while an access or its turnaround gap is in progress.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access in progress, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_bl_n` is 2'b11, `rsp_valid` is low, and `req_ready` is high once the turnaround gap has expired.
- R2: A request is accepted only on an edge where both `req_valid` and `req_ready` are high. `req_ready` is low in every cycle where `mem_cs_n` is low.
- R3: `mem_cs_n` goes low in the cycle after acceptance. It then stays low, with `mem_oe_n` and `mem_we_n` high, for exactly S cycles, where S is timing bits 3:0. When S is 0, the data phase starts in the cycle after acceptance.
- R4: For a read, `mem_oe_n` is low for exactly max(D,1) cycles, where D is timing bits 15:8. `mem_cs_n` and `mem_oe_n` rise on the same edge.
- R5: For a write, `mem_we_n` is low for exactly D+1 cycles, spanning the whole data phase. The controller drives `req_wdata` onto `mem_dq` throughout that phase.
- R6: `mem_bl_n` is 2'b00 for the whole of a read access. For the whole of a write access it equals the bitwise inverse of `req_be`, where bit 0 selects data bits 7:0 and bit 1 selects data bits 15:8.
- R7: `mem_addr` equals the accepted `req_addr` in every cycle of an access and does not change while `mem_cs_n` is low.
- R8: `rsp_valid` is high for exactly one cycle, the first cycle after `mem_cs_n` rises, for both reads and writes. For a read, `rsp_rdata` holds the value on `mem_dq` in the last data-phase cycle.
- R9: Between two accesses, `mem_cs_n` stays high for at least max(T,1) cycles, where T is timing bits 19:16. When a request is already waiting, the gap is exactly max(T,1) cycles.
- R10: Timing bits 31:20 and 7:4 have no effect on any phase length or on the gap.
- R11: The controller drives `mem_dq` only during a write access. It never drives the bus while `mem_oe_n` is low or while `mem_cs_n` is high, so a read returns the value the memory drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| timing_cfg | input | 32 | Timing word: setup [3:0], data length [15:8], turnaround [19:16] |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for a write, active high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid after a read |
| mem_addr | output | 26 | Memory address |
| mem_dq | inout | 16 | Memory data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte-lane strobes, active low |

## Verification
The bench writes and reads the same word in a small memory model. It varies the setup length (0 and 2) and the data length (0, 1, 3 and 255), so that an off-by-one in either counter shows up as a wrong measured phase length. It also varies the direction, which separates the read data length from the write data length. Partial byte-enable writes at the same address are read back, which tells apart which byte each strobe controls. Back-to-back request pairs with turnaround values 0, 1, 2 and 5 expose the exact gap. A timing word with every ignored bit set must give the same timings as one with those bits clear.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int CFG_W     = 32;
  localparam int SETUP_LSB = 0;
  localparam int SETUP_W   = 4;
  localparam int DPH_LSB   = 8;
  localparam int DPH_W     = 8;
  localparam int TURN_LSB  = 16;
  localparam int TURN_W    = 4;
  localparam int DCNT_W    = DPH_W + 1;

  typedef struct packed {
    logic [TURN_W-1:0]  turn;
    logic [DPH_W-1:0]   dlen;
    logic [SETUP_W-1:0] setup;
  } bus_timing_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_DATA  = 2'd2
  } bus_phase_e;
endpackage

// File: rtl/sram_timing_decode.sv
module sram_timing_decode
  import sram_ctrl_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output bus_timing_t      tm
);
  logic unused_cfg_bits;

  assign tm.setup = cfg[SETUP_LSB +: SETUP_W];
  assign tm.dlen  = cfg[DPH_LSB +: DPH_W];
  assign tm.turn  = cfg[TURN_LSB +: TURN_W];

  // fields outside the three timing slices carry no meaning here
  assign unused_cfg_bits = ^{cfg[CFG_W-1:TURN_LSB+TURN_W],
                             cfg[DPH_LSB-1:SETUP_LSB+SETUP_W]};
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CW = DCNT_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_wr,
  input  bus_timing_t tm,
  output bus_phase_e  phase,
  output logic        is_wr,
  output logic        last_data
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] rd_len;
  logic [CW-1:0] wr_len;

  // read data phase never shorter than one cycle; write one cycle longer
  assign rd_len = (tm.dlen == '0) ? CW'(1) : CW'(tm.dlen);
  assign wr_len = CW'(tm.dlen) + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            is_wr <= start_wr;
            if (tm.setup != '0) begin
              phase <= PH_SETUP;
              cnt   <= CW'(tm.setup);
            end else begin
              phase <= PH_DATA;
              cnt   <= start_wr ? wr_len : rd_len;
            end
          end
        end
        PH_SETUP: begin
          if (cnt == CW'(1)) begin
            phase <= PH_DATA;
            cnt   <= is_wr ? wr_len : rd_len;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_DATA: begin
          if (cnt == CW'(1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign last_data = (phase == PH_DATA) && (cnt == CW'(1));
endmodule

// File: rtl/sram_turn_timer.sv
module sram_turn_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] turn,
  output logic          gap_ok
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= turn;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  // the accepting cycle is itself a deselected cycle, hence <= 1
  assign gap_ok = (cnt <= TW'(1));
endmodule

// File: rtl/sram_bus_datapath.sv
module sram_bus_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [LANES-1:0]  in_be,
  input  bus_phase_e        phase,
  input  logic              is_wr,
  input  logic              last_data,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [LANES-1:0]  bl_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              active;
  logic              in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      be_q    <= in_be;
    end
  end

  assign active  = (phase != PH_IDLE);
  assign in_data = (phase == PH_DATA);

  assign mem_addr = addr_q;
  assign cs_n     = !active;
  assign oe_n     = !(in_data && !is_wr);
  assign we_n     = !(in_data && is_wr);
  assign dq_out   = wdata_q;
  assign dq_oe    = active && is_wr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bl_n[i] = !active ? 1'b1 : (is_wr ? !be_q[i] : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= last_data;
      if (last_data && !is_wr) begin
        rsp_rdata <= dq_in;
      end
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  timing_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bl_n
);
  bus_timing_t       tm;
  bus_phase_e        phase;
  logic              is_wr;
  logic              last_data;
  logic              gap_ok;
  logic              accept;
  logic [DATA_W-1:0] dq_out;
  logic              bus_oe;

  sram_timing_decode u_dec (
    .cfg (timing_cfg),
    .tm  (tm)
  );

  assign req_ready = (phase == PH_IDLE) && gap_ok;
  assign accept    = req_valid && req_ready;

  sram_phase_seq #(.CW(DCNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_wr  (req_write),
    .tm        (tm),
    .phase     (phase),
    .is_wr     (is_wr),
    .last_data (last_data)
  );

  sram_turn_timer #(.TW(TURN_W)) u_turn (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (last_data),
    .turn   (tm.turn),
    .gap_ok (gap_ok)
  );

  sram_bus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .in_be     (req_be),
    .phase     (phase),
    .is_wr     (is_wr),
    .last_data (last_data),
    .dq_in     (mem_dq),
    .mem_addr  (mem_addr),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .bl_n      (mem_bl_n),
    .dq_out    (dq_out),
    .dq_oe     (bus_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign mem_dq = bus_oe ? dq_out : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 26,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       timing_cfg,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_bl_n,
  input logic              bus_oe
);
  logic       cs_prev;
  logic [7:0] hi_cnt;
  logic [3:0] turn_q;
  logic [4:0] gap_min;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev <= 1'b1;
      hi_cnt  <= 8'hFF;
      turn_q  <= '0;
    end else begin
      cs_prev <= mem_cs_n;
      if (mem_cs_n) begin
        if (!cs_prev) begin
          hi_cnt <= 8'd1;
          turn_q <= timing_cfg[19:16];
        end else if (hi_cnt != 8'hFF) begin
          hi_cnt <= hi_cnt + 8'd1;
        end
      end
    end
  end

  assign gap_min = (turn_q == '0) ? 5'd1 : {1'b0, turn_q};

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && (&mem_bl_n)));

  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  // R5
  we_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && bus_oe));

  // R6
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_bl_n == '0));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_cs_n && !cs_prev));

  // R9
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && cs_prev) |-> ({3'b000, gap_min} <= hi_cnt));

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || mem_cs_n) |-> !bus_oe);
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .timing_cfg (timing_cfg),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_bl_n   (mem_bl_n),
  .bus_oe     (bus_oe)
);

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_cfg = 32'h0002_0302;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [25:0] mem_addr;
  wire  [15:0] mem_dq;
  logic        mem_cs_n, mem_oe_n, mem_we_n;
  logic [1:0]  mem_bl_n;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n)
  );

  // small memory model, indexed by the low address bits
  logic [15:0] mdl [0:63];
  initial for (int i = 0; i < 64; i++) mdl[i] = 16'h0000;
  assign mem_dq = (!mem_cs_n && !mem_oe_n) ? mdl[mem_addr[5:0]] : 16'hzzzz;
  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin
      if (!mem_bl_n[0]) mdl[mem_addr[5:0]][7:0]  <= mem_dq[7:0];
      if (!mem_bl_n[1]) mdl[mem_addr[5:0]][15:8] <= mem_dq[15:8];
    end
  end

  // bus monitor
  int          setup_n = 0, data_n = 0, hi_run = 1000, gap_last = 0;
  int          rdy_bad = 0, rsp_cnt = 0, rsp_bad = 0;
  logic [25:0] addr0 = '0;
  logic        addr_bad = 1'b0, bl_bad = 1'b0;
  logic [1:0]  bl0 = 2'b11;
  logic [15:0] wd_seen = '0, rsp_data = '0;
  logic        prev_cs = 1'b1, prev_rsp = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n) begin
        if (prev_cs) begin
          setup_n = 0; data_n = 0; addr0 = mem_addr; addr_bad = 1'b0;
          bl0 = mem_bl_n; bl_bad = 1'b0; gap_last = hi_run;
        end
        if (!mem_oe_n || !mem_we_n) data_n++; else setup_n++;
        if (mem_addr !== addr0) addr_bad = 1'b1;
        if (mem_bl_n !== bl0) bl_bad = 1'b1;
        if (!mem_we_n) wd_seen = mem_dq;
        if (req_ready) rdy_bad++;
      end else begin
        if (!prev_cs) hi_run = 1; else hi_run++;
      end
      if (rsp_valid) begin
        rsp_cnt++;
        rsp_data = rsp_rdata;
        if (prev_rsp || !mem_cs_n || prev_cs) rsp_bad++;
      end
      prev_cs = mem_cs_n;
      prev_rsp = rsp_valid;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic [25:0] a, input logic [15:0] d, input logic [1:0] be);
    req_write = w; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic access(input logic w, input logic [25:0] a, input logic [15:0] d, input logic [1:0] be);
    int base;
    base = rsp_cnt;
    push(w, a, d, be);
    while (rsp_cnt < base + 1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access_pair(input logic [25:0] a0, input logic [25:0] a1);
    int base;
    base = rsp_cnt;
    push(1'b0, a0, 16'h0, 2'b11);
    push(1'b0, a1, 16'h0, 2'b11);
    while (rsp_cnt < base + 2) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs_n after reset", mem_cs_n, 1);
    chk("R1 oe_n after reset", mem_oe_n, 1);
    chk("R1 we_n after reset", mem_we_n, 1);
    chk("R1 bl_n after reset", mem_bl_n, 2'b11);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_write_read();
    int base;
    timing_cfg = 32'h0002_0302;
    base = rsp_cnt;
    access(1'b1, 26'h3ABCD05, 16'hA5C3, 2'b11);
    chk("R3 write setup cycles", setup_n, 2);
    chk("R5 write data cycles", data_n, 4);
    chk("R5 write bus data", wd_seen, 16'hA5C3);
    chk("R6 write lanes", bl0, 2'b00);
    chk("R7 write address", addr0, 26'h3ABCD05);
    chk("R7 write address stable", addr_bad, 0);
    chk("R8 write response count", rsp_cnt - base, 1);
    access(1'b0, 26'h3ABCD05, 16'h0, 2'b00);
    chk("R3 read setup cycles", setup_n, 2);
    chk("R4 read data cycles", data_n, 3);
    chk("R6 read lanes", bl0, 2'b00);
    chk("R6 read lanes whole access", bl_bad, 0);
    chk("R7 read address stable", addr_bad, 0);
    chk("R8 R11 read data", rsp_data, 16'hA5C3);
    chk("R8 response timing", rsp_bad, 0);
    chk("R1 idle after access", {mem_cs_n, mem_oe_n, mem_we_n, mem_bl_n}, 5'b11111);
  endtask

  task automatic t_byte_lanes();
    timing_cfg = 32'h0002_0302;
    access(1'b1, 26'h0000005, 16'h1234, 2'b01);
    chk("R6 low lane strobe", bl0, 2'b10);
    chk("R6 low lane strobe held", bl_bad, 0);
    access(1'b0, 26'h0000005, 16'h0, 2'b11);
    chk("R6 low lane merge", rsp_data, 16'hA534);
    access(1'b1, 26'h0000005, 16'h7788, 2'b10);
    chk("R6 high lane strobe", bl0, 2'b01);
    access(1'b0, 26'h0000005, 16'h0, 2'b11);
    chk("R6 high lane merge", rsp_data, 16'h7734);
  endtask

  task automatic t_phase_bounds();
    timing_cfg = 32'h0000_0100;
    access(1'b0, 26'h0000005, 16'h0, 2'b11);
    chk("R3 zero setup", setup_n, 0);
    chk("R4 one-cycle read", data_n, 1);
    chk("R8 zero setup read data", rsp_data, 16'h7734);
    timing_cfg = 32'h0000_0000;
    access(1'b0, 26'h0000005, 16'h0, 2'b11);
    chk("R4 zero length read clamps to 1", data_n, 1);
    access(1'b1, 26'h0000009, 16'hBEEF, 2'b11);
    chk("R5 zero length write is 1", data_n, 1);
    access(1'b0, 26'h0000009, 16'h0, 2'b11);
    chk("R8 short read data", rsp_data, 16'hBEEF);
    timing_cfg = 32'h0000_FF00;
    access(1'b1, 26'h000000A, 16'h0F0F, 2'b11);
    chk("R5 longest write", data_n, 256);
    access(1'b0, 26'h000000A, 16'h0, 2'b11);
    chk("R4 longest read", data_n, 255);
    chk("R8 long read data", rsp_data, 16'h0F0F);
  endtask

  task automatic t_turnaround();
    timing_cfg = 32'h0005_0201;
    access_pair(26'h0000005, 26'h0000009);
    chk("R9 gap of 5", gap_last, 5);
    chk("R8 second read data", rsp_data, 16'hBEEF);
    timing_cfg = 32'h0000_0201;
    access_pair(26'h0000005, 26'h0000009);
    chk("R9 gap with zero turnaround", gap_last, 1);
    timing_cfg = 32'h0001_0201;
    access_pair(26'h0000005, 26'h0000009);
    chk("R9 gap with turnaround 1", gap_last, 1);
    chk("R2 ready low while selected", rdy_bad, 0);
  endtask

  task automatic t_ignored_bits();
    timing_cfg = 32'hFFF2_03F2;
    access(1'b0, 26'h0000005, 16'h0, 2'b11);
    chk("R10 setup unaffected", setup_n, 2);
    chk("R10 data unaffected", data_n, 3);
    access_pair(26'h0000009, 26'h0000005);
    chk("R10 gap unaffected", gap_last, 2);
    chk("R10 read data", rsp_data, 16'h7734);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_byte_lanes();
    t_phase_bounds();
    t_turnaround();
    t_ignored_bits();
    chk("R2 ready low while selected, all tests", rdy_bad, 0);
    chk("R8 response pulse shape, all tests", rsp_bad, 0);
    finish_up();
  end
endmodule